// File: doc/BRIEF.md
# Bus Release Arbiter with Refresh Reclaim

This block belongs to an external memory bus controller. It decides when the shared memory bus may be lent to a master outside the chip and when a memory refresh may run. The outside master asks for the bus on an asynchronous request line. The arbiter answers on an acknowledge line. It also issues single-cycle commands to the access sequencer: grant the bus away, start a refresh, or precharge all banks.

The sequencer reports three things: that its current cycle has finished, that it is inside an indivisible group of cycles, and that the SDRAM runs with rows left open. Neither a hand-over nor a refresh may split an indivisible group. Such groups are a wide access split into several port-width cycles, a burst line fill or write-back, or a read-then-write pair. A refresh that becomes due while the bus is lent out is not run at once. The arbiter drops the acknowledge to ask for the bus back, and runs the refresh only after the outside master has withdrawn its request.

Top module: `bus_release_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `back_o`, `grant_o`, `pall_o` and `refresh_start_o` are 0. No refresh is pending and the arbiter owns the bus.
- R2: `breq_in` passes through `SYNC_STAGES` flops before the arbiter uses it. Take `SYNC_STAGES`=2, `cyc_done`=1, `atomic_busy`=0 and `rowopen_mode`=0, with the arbiter idle. If `breq_in` rises before clock edge e0, `back_o` is 1 from edge e2 onward and is still 0 after edge e1.
- R3: The arbiter changes state only on an edge where `cyc_done` is 1. While `cyc_done` is 0, `back_o` holds and no command is issued.
- R4: While `atomic_busy` is 1, an idle arbiter starts neither a grant nor a refresh, however long the request has been present.
- R5: When a refresh is pending and the bus request is present at the same cycle boundary, the refresh runs first and the grant follows.
- R6: Refresh request pulses that arrive while a refresh is already pending merge into one. A single `refresh_start_o` pulse serves all of them and clears the pending flag.
- R7: No refresh starts while `back_o` is 1. If a refresh becomes pending while the bus is granted, `back_o` falls at the next `cyc_done` boundary.
- R8: After reclaiming the bus, the arbiter waits for the synchronized request to fall before it starts the refresh. In non-row-open mode `refresh_start_o` is 1 two edges after the edge that first samples `breq_in`=0 in the synchronizer.
- R9: When the synchronized request falls while the bus is granted and no refresh is pending, `back_o` falls at that boundary and the arbiter owns the bus again.
- R10: With `rowopen_mode`=1, a `pall_o` pulse comes before every `refresh_start_o` and before every `grant_o`. That adds one boundary of latency. With `rowopen_mode`=0, `pall_o` never pulses.
- R11: `grant_o` and `refresh_start_o` are one-cycle pulses. `grant_o` is 1 exactly in the first cycle that `back_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| breq_in | input | 1 | Asynchronous bus request from the outside master, active high |
| cyc_done | input | 1 | Sequencer: current bus cycle has finished this clock |
| atomic_busy | input | 1 | Sequencer: an indivisible group of cycles is in progress |
| rowopen_mode | input | 1 | SDRAM rows are left open between accesses |
| refresh_req | input | 1 | One-cycle refresh request pulse from the interval timer |
| back_o | output | 1 | Bus acknowledge to the outside master, active high |
| grant_o | output | 1 | One-cycle command: hand the bus to the outside master |
| refresh_start_o | output | 1 | One-cycle command: start a refresh cycle |
| pall_o | output | 1 | One-cycle command: precharge all banks |

## Verification
The bench builds the block with the default two-stage synchronizer. Every latency is therefore a small fixed edge count that the bench derives from the edge at which the request changes. Each scenario runs once in each row mode, so the extra precharge boundary shows up as a one-edge shift and as an interleaved event order. The atomic hold is swept over two lengths. Request pulses are stacked while boundaries are withheld, which exercises merging and refresh-over-grant priority. A refresh arriving during a grant drives the reclaim path through its wait on the request.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PRECHARGE = 3'd1,
    ST_GRANTED   = 3'd2,
    ST_RECLAIM   = 3'd3,
    ST_REFRESH   = 3'd4
  } arb_state_t;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/arb_refresh_pend.sv
module arb_refresh_pend (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic clr,
  output logic pend
);
  // A new request in the clearing cycle survives as a fresh pending refresh.
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~clr) | req;
  end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic breq_s,
  input  logic cyc_done,
  input  logic atomic_busy,
  input  logic rowopen_mode,
  input  logic pend,
  output logic clr_pend,
  output logic back_o,
  output logic grant_o,
  output logic refresh_start_o,
  output logic pall_o
);
  arb_state_t state, nxt;
  logic       tgt_ref, nxt_tgt_ref;
  logic       boundary;

  assign boundary = cyc_done & ~atomic_busy;

  always_comb begin
    nxt         = state;
    nxt_tgt_ref = tgt_ref;
    unique case (state)
      ST_IDLE: begin
        if (boundary) begin
          if (pend) begin
            nxt_tgt_ref = 1'b1;
            nxt         = rowopen_mode ? ST_PRECHARGE : ST_REFRESH;
          end else if (breq_s) begin
            nxt_tgt_ref = 1'b0;
            nxt         = rowopen_mode ? ST_PRECHARGE : ST_GRANTED;
          end
        end
      end
      ST_PRECHARGE: begin
        if (cyc_done) begin
          if (tgt_ref || pend) nxt = ST_REFRESH;
          else if (breq_s)     nxt = ST_GRANTED;
          else                 nxt = ST_IDLE;
        end
      end
      ST_GRANTED: begin
        if (cyc_done) begin
          if (pend)         nxt = ST_RECLAIM;
          else if (!breq_s) nxt = ST_IDLE;
        end
      end
      ST_RECLAIM: begin
        if (cyc_done && !breq_s) begin
          nxt_tgt_ref = 1'b1;
          nxt         = rowopen_mode ? ST_PRECHARGE : ST_REFRESH;
        end
      end
      ST_REFRESH: begin
        if (cyc_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign clr_pend = (nxt == ST_REFRESH) && (state != ST_REFRESH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      tgt_ref         <= 1'b0;
      back_o          <= 1'b0;
      grant_o         <= 1'b0;
      refresh_start_o <= 1'b0;
      pall_o          <= 1'b0;
    end else begin
      state           <= nxt;
      tgt_ref         <= nxt_tgt_ref;
      back_o          <= (nxt == ST_GRANTED);
      grant_o         <= (nxt == ST_GRANTED) && (state != ST_GRANTED);
      refresh_start_o <= clr_pend;
      pall_o          <= (nxt == ST_PRECHARGE) && (state != ST_PRECHARGE);
    end
  end
endmodule

// File: rtl/bus_release_arbiter.sv
module bus_release_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic breq_in,
  input  logic cyc_done,
  input  logic atomic_busy,
  input  logic rowopen_mode,
  input  logic refresh_req,
  output logic back_o,
  output logic grant_o,
  output logic refresh_start_o,
  output logic pall_o
);
  logic breq_s;
  logic pend;
  logic clr_pend;

  arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (breq_in),
    .q_out (breq_s)
  );

  arb_refresh_pend u_pend (
    .clk  (clk),
    .rst  (rst),
    .req  (refresh_req),
    .clr  (clr_pend),
    .pend (pend)
  );

  arb_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .breq_s          (breq_s),
    .cyc_done        (cyc_done),
    .atomic_busy     (atomic_busy),
    .rowopen_mode    (rowopen_mode),
    .pend            (pend),
    .clr_pend        (clr_pend),
    .back_o          (back_o),
    .grant_o         (grant_o),
    .refresh_start_o (refresh_start_o),
    .pall_o          (pall_o)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic clk,
  input logic rst,
  input logic cyc_done,
  input logic rowopen_mode,
  input logic back_o,
  input logic grant_o,
  input logic refresh_start_o,
  input logic pall_o
);
  logic pall_seen;

  always_ff @(posedge clk) begin
    if (rst)                             pall_seen <= 1'b0;
    else if (refresh_start_o || grant_o) pall_seen <= 1'b0;
    else if (pall_o)                     pall_seen <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!back_o && !grant_o && !refresh_start_o && !pall_o));

  a_r3_hold_without_done: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cyc_done)) |-> ($stable(back_o) && !grant_o && !refresh_start_o && !pall_o));

  a_r7_no_refresh_while_granted: assert property (@(posedge clk) disable iff (rst)
    refresh_start_o |-> !back_o);

  a_r10_pall_first: assert property (@(posedge clk) disable iff (rst)
    ((refresh_start_o || grant_o) && $past(rowopen_mode) && !$past(rst)) |-> pall_seen);

  a_r11_grant_with_back: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> (back_o && !$past(back_o)));

  a_r11_refresh_pulse: assert property (@(posedge clk) disable iff (rst)
    refresh_start_o |=> !refresh_start_o);
endmodule

bind bus_release_arbiter arb_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .cyc_done        (cyc_done),
  .rowopen_mode    (rowopen_mode),
  .back_o          (back_o),
  .grant_o         (grant_o),
  .refresh_start_o (refresh_start_o),
  .pall_o          (pall_o)
);

// File: tb/bus_release_arbiter_tb.sv
module bus_release_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EV_P = 1, EV_R = 2, EV_G = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic breq_in = 1'b0, cyc_done = 1'b0, atomic_busy = 1'b0;
  logic rowopen_mode = 1'b0, refresh_req = 1'b0;
  logic back_o, grant_o, refresh_start_o, pall_o;

  int n_checks = 0, n_fail = 0;
  int n_pall = 0, n_ref = 0, n_grant = 0;
  int ev [0:255];
  int ev_n = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_release_arbiter #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .breq_in(breq_in), .cyc_done(cyc_done),
    .atomic_busy(atomic_busy), .rowopen_mode(rowopen_mode),
    .refresh_req(refresh_req), .back_o(back_o), .grant_o(grant_o),
    .refresh_start_o(refresh_start_o), .pall_o(pall_o)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (pall_o)          begin n_pall++;  if (ev_n < 256) ev[ev_n] = EV_P; ev_n++; end
      if (refresh_start_o) begin n_ref++;   if (ev_n < 256) ev[ev_n] = EV_R; ev_n++; end
      if (grant_o)         begin n_grant++; if (ev_n < 256) ev[ev_n] = EV_G; ev_n++; end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_ev(input int idx, input int exp, input string tag);
    int a;
    a = (idx < ev_n && idx < 256) ? ev[idx] : 0;
    check(a == exp, tag, a, exp);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base, r0, p0, m;
    tick(3);
    rst = 1'b0;
    cyc_done = 1'b1;
    tick(1);
    // R1: quiet after reset
    check(!back_o && !grant_o && !pall_o && !refresh_start_o, "R1 outputs after reset",
          {back_o, grant_o, pall_o, refresh_start_o}, 0);
    tick(4);
    check(n_ref == 0 && n_pall == 0, "R1 nothing pending after reset", n_ref + n_pall, 0);

    for (int mi = 0; mi < 2; mi++) begin
      m = mi;
      rowopen_mode = (mi == 1);
      tick(2);

      // R2 / R10 / R11: grant latency
      base = ev_n;
      breq_in = 1'b1;
      tick(2 + m);
      check(back_o == 1'b0, "R2 back still low one edge early", back_o, 0);
      tick(1);
      check(back_o == 1'b1, "R2 back high at synced latency", back_o, 1);
      check(grant_o == 1'b1, "R11 grant pulse with back rise", grant_o, 1);
      tick(1);
      check(grant_o == 1'b0, "R11 grant is one cycle", grant_o, 0);
      if (m == 1) begin
        check_ev(base, EV_P, "R10 pall before grant");
        check_ev(base + 1, EV_G, "R10 grant after pall");
      end else begin
        check_ev(base, EV_G, "R10 no pall in closed-row mode");
      end

      // R9: release
      breq_in = 1'b0;
      tick(2);
      check(back_o == 1'b1, "R9 back held until synced release", back_o, 1);
      tick(1);
      check(back_o == 1'b0, "R9 back drops on release", back_o, 0);
      tick(3);

      // R3: no boundary, nothing moves
      cyc_done = 1'b0;
      breq_in = 1'b1;
      p0 = n_pall;
      tick(6);
      check(back_o == 1'b0 && n_pall == p0, "R3 held without cyc_done", back_o, 0);
      cyc_done = 1'b1;
      tick(1 + m);
      check(back_o == 1'b1, "R3 moves on first cyc_done", back_o, 1);
      breq_in = 1'b0;
      tick(5);
      check(back_o == 1'b0, "R3 release returns idle", back_o, 0);

      // R4 / R5: atomic hold, then refresh before grant
      for (int h = 1; h <= 3; h += 2) begin
        base = ev_n;
        r0 = n_ref;
        atomic_busy = 1'b1;
        breq_in = 1'b1;
        refresh_req = 1'b1;
        tick(1);
        refresh_req = 1'b0;
        tick(h + 5);
        check(n_ref == r0 && back_o == 1'b0 && ev_n == base, "R4 atomic group holds off",
              ev_n - base, 0);
        atomic_busy = 1'b0;
        tick(10);
        check(back_o == 1'b1, "R5 grant follows refresh", back_o, 1);
        if (m == 1) begin
          check_ev(base, EV_P, "R5 pall first");
          check_ev(base + 1, EV_R, "R5 refresh before grant");
          check_ev(base + 2, EV_P, "R10 pall before grant");
          check_ev(base + 3, EV_G, "R5 grant last");
        end else begin
          check_ev(base, EV_R, "R5 refresh before grant");
          check_ev(base + 1, EV_G, "R5 grant last");
        end
        breq_in = 1'b0;
        tick(5);
      end

      // R6: merged requests
      r0 = n_ref;
      p0 = n_pall;
      cyc_done = 1'b0;
      for (int k = 0; k < 3; k++) begin
        refresh_req = 1'b1;
        tick(1);
        refresh_req = 1'b0;
        tick(2);
      end
      cyc_done = 1'b1;
      tick(8);
      check(n_ref == r0 + 1, "R6 merged into one refresh", n_ref - r0, 1);
      check(n_pall == p0 + m, "R10 pall count for refresh", n_pall - p0, m);

      // R7 / R8: reclaim
      breq_in = 1'b1;
      tick(8);
      check(back_o == 1'b1, "R7 setup granted", back_o, 1);
      r0 = n_ref;
      refresh_req = 1'b1;
      tick(1);
      refresh_req = 1'b0;
      check(back_o == 1'b1, "R7 back held one edge", back_o, 1);
      tick(1);
      check(back_o == 1'b0, "R7 back dropped to reclaim", back_o, 0);
      tick(6);
      check(n_ref == r0 && back_o == 1'b0, "R8 refresh waits for request drop", n_ref - r0, 0);
      breq_in = 1'b0;
      tick(2);
      check(refresh_start_o == 1'b0 && pall_o == 1'b0, "R8 not before synced drop",
            {refresh_start_o, pall_o}, 0);
      tick(1);
      if (m == 0)
        check(refresh_start_o == 1'b1, "R8 refresh starts after drop", refresh_start_o, 1);
      else
        check(pall_o == 1'b1, "R10 pall before reclaimed refresh", pall_o, 1);
      tick(6);
      check(n_ref == r0 + 1 && back_o == 1'b0, "R8 one refresh after reclaim", n_ref - r0, 1);
    end

    check(n_grant > 0, "R11 grants observed", n_grant, 1);
    finish_run();
  end
endmodule